// File: doc/BRIEF.md
# Dual-Channel Converter Serial Load Controller

This block is the digital front end of a two-channel digital-to-analog converter. A host writes frames over a three-wire serial link (data, serial clock, active-low select). Each frame carries a two-bit channel address followed by a code word, most significant bit first. When select returns high, the most recent frame's worth of bits is decoded. The code is written into the input register of channel A, channel B, both or neither.

Each channel also has an output register that feeds the analog section. An active-low, level-sensitive load strobe makes both output registers follow their input registers. A host can therefore stage two codes and then move them to the outputs together. A clear pin forces all four registers to zero or to midscale, and a preset strap pin picks which. All serial and control pins are asynchronous. They are brought into the system clock through two-flop synchronisers, and the system clock must run at least four times faster than the serial clock.

Top module: `dual_dac_ctrl`

## Requirements
- R1: A frame is FRAME_W = CODE_W + 2 bits, shifted in MSB first. Its first two bits are the address {A1,A0} and the remaining CODE_W bits are the code.
- R2: A bit is taken from `sdi` only on a rising edge of `sclk` while `sel_n` is low. Clock edges while `sel_n` is high have no effect.
- R3: When `sel_n` rises, only the last FRAME_W bits received are decoded. Extra leading bits, such as 6 pad bits in a 24-bit transfer, are discarded.
- R4: The address {A1,A0} selects the target of the write: 00 writes no register, 01 writes channel A, 10 writes channel B and 11 writes the same code to both channels.
- R5: While `ld_n` is low, each output register follows its input register, including a write in the same cycle. While `ld_n` is high, the output registers hold.
- R6: While `clr_n` is low, all four registers are forced to the preset value, whatever `ld_n` is. The preset value is 0 when `preset_mid` is 0 and 1 << (CODE_W-1) when it is 1 (0x8000 for 16 bits).
- R7: After the system reset `rst_n`, all four registers hold the preset value selected by `preset_mid`, and the shift register is all zeros.
- R8: A frame with fewer than FRAME_W bits still commits the shift register contents, meaning the most recent bits received since reset. It sets `short_frame`, and the next frame of FRAME_W or more bits clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low system reset |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| sel_n | input | 1 | Active-low frame select; its rising edge commits the frame |
| ld_n | input | 1 | Active-low level-sensitive output load strobe |
| clr_n | input | 1 | Active-low clear to the preset value |
| preset_mid | input | 1 | Preset choice: 0 gives zero, 1 gives midscale |
| code_a | output | CODE_W | Channel A output register |
| code_b | output | CODE_W | Channel B output register |
| short_frame | output | 1 | Last committed frame had fewer than FRAME_W bits |

## Verification
The hardest case to reach is a short frame, because the code it commits mixes leftover bits from earlier transfers with the new ones. The bench keeps its own copy of the shift history from reset onward. It sends short, full and padded frames back to back in a random order, so that the leftover bits differ each time. Serial clock pulses are also issued with select high, and the bench shows through the next short frame that none of them entered the history.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

  localparam int ADDR_W = 2;

  typedef struct packed {
    logic load_b;
    logic load_a;
  } chan_sel_t;

  // Address {A1,A0}: A0 targets channel A, A1 targets channel B.
  function automatic chan_sel_t decode_addr(input logic [ADDR_W-1:0] addr);
    chan_sel_t s;
    s.load_a = addr[0];
    s.load_b = addr[1];
    return s;
  endfunction

  // Preset word: zero, or only the top bit of a w-bit code set.
  function automatic logic [31:0] preset_word(input logic mid, input int w);
    return mid ? (32'd1 << (w - 1)) : 32'd0;
  endfunction

endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/dac_shifter.sv
module dac_shifter
  import dac_ctrl_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_q,
  input  logic              sdi_q,
  input  logic              sel_q,
  output logic              shift_en,
  output logic              commit,
  output logic [ADDR_W-1:0] cmt_addr,
  output logic [CODE_W-1:0] cmt_data,
  output logic [CODE_W+ADDR_W-1:0] sr_o,
  output logic              full_cnt,
  output logic              short_frame
);
  localparam int FRAME_W = CODE_W + ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W);

  logic               sclk_d, sel_d;
  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   cnt;

  assign shift_en = sclk_q & ~sclk_d & ~sel_q;
  assign commit   = sel_q & ~sel_d;
  assign cmt_addr = sr[FRAME_W-1 -: ADDR_W];
  assign cmt_data = sr[CODE_W-1:0];
  assign sr_o     = sr;
  assign full_cnt = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d      <= 1'b0;
      sel_d       <= 1'b1;
      sr          <= '0;
      cnt         <= '0;
      short_frame <= 1'b0;
    end else begin
      sclk_d <= sclk_q;
      sel_d  <= sel_q;
      if (shift_en) begin
        sr <= {sr[FRAME_W-2:0], sdi_q};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
      if (commit) begin
        short_frame <= ~full_cnt;
        cnt         <= '0;
      end else if (sel_q) begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_ctrl_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_mid,
  input  logic              clr_act,
  input  logic              mid_q,
  input  logic              load,
  input  logic [CODE_W-1:0] data,
  input  logic              ld_act,
  output logic [CODE_W-1:0] in_q,
  output logic [CODE_W-1:0] out_q
);
  logic [CODE_W-1:0] in_d;

  always_comb begin
    in_d = in_q;
    if (load) in_d = data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q  <= CODE_W'(preset_word(strap_mid, CODE_W));
      out_q <= CODE_W'(preset_word(strap_mid, CODE_W));
    end else if (clr_act) begin
      in_q  <= CODE_W'(preset_word(mid_q, CODE_W));
      out_q <= CODE_W'(preset_word(mid_q, CODE_W));
    end else begin
      in_q <= in_d;
      if (ld_act) out_q <= in_d;
    end
  end
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              sel_n,
  input  logic              ld_n,
  input  logic              clr_n,
  input  logic              preset_mid,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              short_frame
);
  localparam int FRAME_W = CODE_W + ADDR_W;
  localparam int N_CH    = 2;

  logic sclk_q, sdi_q, sel_q, ld_q, clr_q, mid_q;

  dac_sync #(.W(6), .RST_VAL(6'b001110)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk, sdi, sel_n, ld_n, clr_n, preset_mid}),
    .q     ({sclk_q, sdi_q, sel_q, ld_q, clr_q, mid_q})
  );

  // Named internal events for the checker.
  logic               shift_en, commit, full_cnt;
  logic [ADDR_W-1:0]  cmt_addr;
  logic [CODE_W-1:0]  cmt_data;
  logic [FRAME_W-1:0] sr_q;
  logic               clr_act, ld_act;
  chan_sel_t          csel;
  logic [N_CH-1:0]    load_vec;
  logic [CODE_W-1:0]  in_regs  [N_CH];
  logic [CODE_W-1:0]  out_regs [N_CH];

  assign clr_act  = ~clr_q;
  assign ld_act   = ~ld_q;
  assign csel     = decode_addr(cmt_addr);
  assign load_vec = {csel.load_b, csel.load_a} & {N_CH{commit}};

  dac_shifter #(.CODE_W(CODE_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_q      (sclk_q),
    .sdi_q       (sdi_q),
    .sel_q       (sel_q),
    .shift_en    (shift_en),
    .commit      (commit),
    .cmt_addr    (cmt_addr),
    .cmt_data    (cmt_data),
    .sr_o        (sr_q),
    .full_cnt    (full_cnt),
    .short_frame (short_frame)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dac_chan #(.CODE_W(CODE_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_mid (preset_mid),
      .clr_act   (clr_act),
      .mid_q     (mid_q),
      .load      (load_vec[c]),
      .data      (cmt_data),
      .ld_act    (ld_act),
      .in_q      (in_regs[c]),
      .out_q     (out_regs[c])
    );
  end

  assign code_a = out_regs[0];
  assign code_b = out_regs[1];
endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk #(
  parameter int CODE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                shift_en,
  input logic                sdi_q,
  input logic                sel_q,
  input logic                commit,
  input logic [1:0]          cmt_addr,
  input logic [CODE_W-1:0]   cmt_data,
  input logic [CODE_W+1:0]   sr_q,
  input logic                full_cnt,
  input logic                clr_act,
  input logic                ld_act,
  input logic                mid_q,
  input logic [CODE_W-1:0]   in_a,
  input logic [CODE_W-1:0]   in_b,
  input logic [CODE_W-1:0]   code_a,
  input logic [CODE_W-1:0]   code_b,
  input logic                short_frame
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr_q[0] == $past(sdi_q) && sr_q[CODE_W+1:1] == $past(sr_q[CODE_W:0]));

  a_r2_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |=> $stable(sr_q));

  a_r4_none: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cmt_addr == 2'b00 && !clr_act) |=> $stable(in_a) && $stable(in_b));

  a_r4_chan_a: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cmt_addr[0] && !clr_act) |=> in_a == $past(cmt_data));

  a_r4_chan_b: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cmt_addr[1] && !clr_act) |=> in_b == $past(cmt_data));

  a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_act && !clr_act) |=> code_a == in_a && code_b == in_b);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_act && !clr_act) |=> $stable(code_a) && $stable(code_b));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> code_a == ($past(mid_q) ? MID : '0) && in_b == code_a
                && in_a == code_a && code_b == code_a);

  a_r8_full_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && full_cnt) |=> !short_frame);

  a_r8_short_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !full_cnt) |=> short_frame);
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .shift_en    (shift_en),
  .sdi_q       (sdi_q),
  .sel_q       (sel_q),
  .commit      (commit),
  .cmt_addr    (cmt_addr),
  .cmt_data    (cmt_data),
  .sr_q        (sr_q),
  .full_cnt    (full_cnt),
  .clr_act     (clr_act),
  .ld_act      (ld_act),
  .mid_q       (mid_q),
  .in_a        (in_regs[0]),
  .in_b        (in_regs[1]),
  .code_a      (code_a),
  .code_b      (code_b),
  .short_frame (short_frame)
);

// File: tb/dual_dac_ctrl_tb.sv
`timescale 1ns/1ps
module dual_dac_ctrl_tb;
  localparam int W  = 16;
  localparam int FW = W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, sel_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1, preset_mid = 1'b0;
  logic [W-1:0] code_a, code_b;
  logic short_frame;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Bench model state.
  logic [31:0]  msr;
  logic [W-1:0] m_in_a, m_in_b, m_out_a, m_out_b;
  logic         m_short;

  always #2 clk = ~clk;

  dual_dac_ctrl #(.CODE_W(W)) u_dut (
    .clk (clk), .rst_n (rst_n), .sclk (sclk), .sdi (sdi), .sel_n (sel_n),
    .ld_n (ld_n), .clr_n (clr_n), .preset_mid (preset_mid),
    .code_a (code_a), .code_b (code_b), .short_frame (short_frame)
  );

  function automatic logic [W-1:0] exp_preset(input logic mid);
    return mid ? W'(1 << (W - 1)) : '0;
  endfunction

  function automatic logic [31:0] low_mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  task automatic check(input string req);
    n_tests++;
    if (code_a !== m_out_a || code_b !== m_out_b || short_frame !== m_short) begin
      n_fail++;
      $display("FAIL %s: got a=%h b=%h short=%b, expected a=%h b=%h short=%b",
               req, code_a, code_b, short_frame, m_out_a, m_out_b, m_short);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic mid);
    preset_mid = mid;
    rst_n = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    msr = '0;
    m_in_a = exp_preset(mid); m_in_b = m_in_a;
    m_out_a = m_in_a; m_out_b = m_in_a;
    m_short = 1'b0;
  endtask

  task automatic send_frame(input int n, input logic [31:0] v);
    logic [W-1:0] data;
    logic [1:0]   addr;
    sel_n = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    sel_n = 1'b1;
    wait_clk(8);
    msr  = ((msr << n) | (v & low_mask(n))) & low_mask(FW);
    addr = msr[FW-1 -: 2];
    data = msr[W-1:0];
    if (addr[0]) m_in_a = data;
    if (addr[1]) m_in_b = data;
    m_short = (n < FW);
    if (!ld_n) begin m_out_a = m_in_a; m_out_b = m_in_b; end
  endtask

  task automatic set_ld(input logic v);
    ld_n = v;
    wait_clk(6);
    if (!v) begin m_out_a = m_in_a; m_out_b = m_in_b; end
  endtask

  task automatic pulse_ld();
    set_ld(1'b0);
    set_ld(1'b1);
  endtask

  task automatic do_clear(input logic mid);
    preset_mid = mid;
    wait_clk(4);
    clr_n = 1'b0;
    wait_clk(6);
    clr_n = 1'b1;
    wait_clk(6);
    m_in_a = exp_preset(mid); m_in_b = m_in_a;
    m_out_a = m_in_a; m_out_b = m_in_a;
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R7: power-on value with zero strap.
    do_reset(1'b0);
    check("R7 reset zero");

    // R1/R4: write channel A only, held; then load strobe.
    send_frame(FW, {14'd0, 2'b01, 16'hA5C3});
    check("R5 hold while ld_n high");
    pulse_ld();
    check("R4 addr 01 -> channel A");

    // R4: channel B with ld_n tied low.
    set_ld(1'b0);
    send_frame(FW, {14'd0, 2'b10, 16'h1234});
    check("R4 addr 10 -> channel B");
    send_frame(FW, {14'd0, 2'b11, 16'hBEEF});
    check("R4 addr 11 -> both");
    send_frame(FW, {14'd0, 2'b00, 16'h7777});
    check("R4 addr 00 -> none");

    // R3: 24-bit transfer with pad bits.
    send_frame(24, {8'd0, 6'b111111, 2'b01, 16'h0F0F});
    check("R3 padded frame");

    // R6: clear to midscale while ld_n high.
    set_ld(1'b1);
    do_clear(1'b1);
    check("R6 clear midscale");
    do_clear(1'b0);
    check("R6 clear zero");

    // R8: short frame commits leftover history.
    set_ld(1'b0);
    send_frame(7, 32'h55);
    check("R8 short frame");
    send_frame(FW, {14'd0, 2'b11, 16'h8001});
    check("R8 full frame clears flag");

    // R2: clock pulses with select high are ignored.
    for (int k = 0; k < 5; k++) begin
      sdi = 1'b1; wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
    end
    wait_clk(4);
    send_frame(4, 32'h0);
    check("R2 clocks ignored while deselected");

    // R7: reset with midscale strap.
    do_reset(1'b1);
    check("R7 reset midscale");

    // Random mix.
    for (int it = 0; it < 60; it++) begin
      int op;
      op = int'($urandom % 10);
      if (op == 0) begin
        do_clear(1'($urandom));
        check("R6 random clear");
      end else if (op == 1) begin
        pulse_ld();
        check("R5 random load pulse");
      end else if (op == 2) begin
        set_ld(1'($urandom % 2));
        check("R5 random strobe level");
      end else begin
        int n;
        int r;
        r = int'($urandom % 6);
        n = (r == 0) ? 24 : (r == 1) ? int'(3 + $urandom % 14) : FW;
        send_frame(n, $urandom);
        check(n < FW ? "R8 random short" : (n > FW ? "R3 random padded" : "R1 random frame"));
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule